// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Mask

This block is the purely combinational arithmetic and logic stage of a small accumulator-based processor. Each cycle the sequencer presents an operation code, the accumulator value, a memory operand and the current carry flag. The block returns the new result, the next values of the four condition flags (negative, overflow, zero, carry) and a per-flag write mask. The flag register writes only the flags whose mask bit is set, so every operation changes exactly the flags it owns.

Unary operations (shifts, rotates, increment, decrement and pass-through) act on either the accumulator or the memory operand, as chosen by `use_mem`. Compare and bit test never change the result: the result port returns the accumulator unchanged for them. Decimal arithmetic, operand fetch and register storage live elsewhere.

The flag vector and the mask share one layout: bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. In every operation a flag bit whose mask bit is clear is driven to 0.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) gives res = (a + m + c_in) mod 256, with C = carry out of bit 7, V = signed overflow, N = res bit 7, Z = (res == 0), and mask 4'b1111.
- R2: Op code 1 (subtract) gives res = a + ~m + c_in, with c_in = 1 meaning no borrow. C = carry out (1 = no borrow). V, N and Z follow the R1 rules, and the mask is 4'b1111.
- R3: Op code 5 (compare) sets C = (a >= m), Z = (a == m) and N = bit 7 of (a - m) mod 256. The mask is 4'b1011 and res equals a.
- R4: Op codes 2, 3 and 4 give a AND m, a OR m and a XOR m. N and Z come from the result, and the mask is 4'b1010.
- R5: Op code 6 (shift left) and op code 7 (shift right) insert 0. C takes the bit shifted out: old bit 7 on a left shift, old bit 0 on a right shift. The mask is 4'b1011.
- R6: Op code 8 (rotate left) places c_in at bit 0, and op code 9 (rotate right) places c_in at bit 7. C takes the bit that falls out, and the mask is 4'b1011.
- R7: Op code 10 (increment) and op code 11 (decrement) wrap modulo 256. They act on m when use_mem = 1 and on a when use_mem = 0, and the mask is 4'b1010.
- R8: Op code 12 (bit test) sets Z = ((a AND m) == 0), N = m bit 7 and V = m bit 6. The mask is 4'b1110 and res equals a.
- R9: Op code 13 (bit test, immediate form) sets only Z = ((a AND m) == 0). The mask is 4'b0010 and res equals a.
- R10: Op code 14 (pass-through) returns m when use_mem = 1 and a when use_mem = 0. N and Z come from the result, and the mask is 4'b1010.
- R11: Flag bits whose mask bit is clear read 0. The reserved op code 15 returns res = a with mask 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| use_mem | input | 1 | Unary operand select: 1 = memory operand, 0 = accumulator |
| a_in | input | WIDTH | Accumulator operand |
| m_in | input | WIDTH | Memory operand |
| c_in | input | 1 | Current carry flag |
| res_out | output | WIDTH | Result value |
| flag_nxt | output | 4 | Next flag values {N,V,Z,C} |
| flag_we | output | 4 | Per-flag write mask {N,V,Z,C} |

## Verification
Several flag rules can fire together on a single operation. An add of 0x80 and 0x80 produces a zero result, a carry out and a signed overflow at once. A rotate right with c_in set moves the old bit 0 into C while the old carry becomes the new sign bit. The bench drives these coincident cases as directed vectors with hand-computed expectations. It then sweeps every op code with random operands and carry against a behavioural integer model, so that coincident flag events are compared on every clock.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_CMP  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_ROTL = 4'd8,
        OP_ROTR = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_TST  = 4'd12,
        OP_TSTI = 4'd13,
        OP_PASS = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t MASK_ALL  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
    localparam flags_t MASK_NZC  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
    localparam flags_t MASK_NZ   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
    localparam flags_t MASK_NVZ  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
    localparam flags_t MASK_Z    = '{n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0};
    localparam flags_t MASK_NONE = '0;

    function automatic logic is_right(input alu_op_e op);
        return (op == OP_SHR) || (op == OP_ROTR);
    endfunction

    function automatic logic is_rotate(input alu_op_e op);
        return (op == OP_ROTL) || (op == OP_ROTR);
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide;

    assign wide = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, ci};
    assign sum  = wide[MSB:0];
    assign co   = wide[WIDTH];
    // Signed overflow: operands agree in sign, result disagrees
    assign ovf  = (x_in[MSB] == y_in[MSB]) && (sum[MSB] != x_in[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] m_in,
    output logic [WIDTH-1:0] and_r,
    output logic [WIDTH-1:0] or_r,
    output logic [WIDTH-1:0] xor_r
);
    assign and_r = a_in & m_in;
    assign or_r  = a_in | m_in;
    assign xor_r = a_in ^ m_in;
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    input  logic             right_dir,
    input  logic             fill,
    output logic [WIDTH-1:0] dout,
    output logic             out_bit
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] lft;
    logic [WIDTH-1:0] rgt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign lft[i] = fill;
        end else begin : g_lo_mid
            assign lft[i] = din[i-1];
        end
        if (i == MSB) begin : g_hi
            assign rgt[i] = fill;
        end else begin : g_hi_mid
            assign rgt[i] = din[i+1];
        end
    end

    assign dout    = right_dir ? rgt : lft;
    assign out_bit = right_dir ? din[0] : din[MSB];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_sel,
    input  logic             use_mem,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] m_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] res_out,
    output logic [3:0]       flag_nxt,
    output logic [3:0]       flag_we
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] unary;

    logic [WIDTH-1:0] add_x, add_y, add_sum;
    logic             add_ci, add_co, add_ovf;
    logic [WIDTH-1:0] and_r, or_r, xor_r;
    logic [WIDTH-1:0] sh_out;
    logic             sh_bit;

    flags_t           nf, we;
    logic [WIDTH-1:0] res;

    assign op    = alu_op_e'(op_sel);
    assign unary = use_mem ? m_in : a_in;

    // Adder operand steering
    always_comb begin
        add_x  = a_in;
        add_y  = m_in;
        add_ci = c_in;
        unique case (op)
            OP_SUB: add_y = ~m_in;
            OP_CMP: begin
                add_y  = ~m_in;
                add_ci = 1'b1;
            end
            OP_INC: begin
                add_x  = unary;
                add_y  = '0;
                add_ci = 1'b1;
            end
            OP_DEC: begin
                add_x  = unary;
                add_y  = '1;
                add_ci = 1'b0;
            end
            default: ;
        endcase
    end

    acc_alu_adder #(.WIDTH(WIDTH)) adder_i (
        .x_in (add_x),
        .y_in (add_y),
        .ci   (add_ci),
        .sum  (add_sum),
        .co   (add_co),
        .ovf  (add_ovf)
    );

    acc_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .a_in  (a_in),
        .m_in  (m_in),
        .and_r (and_r),
        .or_r  (or_r),
        .xor_r (xor_r)
    );

    acc_alu_shift #(.WIDTH(WIDTH)) shift_i (
        .din       (unary),
        .right_dir (is_right(op)),
        .fill      (is_rotate(op) & c_in),
        .dout      (sh_out),
        .out_bit   (sh_bit)
    );

    // Result select and per-operation flag rules
    always_comb begin
        res = a_in;
        nf  = '0;
        we  = MASK_NONE;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res  = add_sum;
                nf.n = add_sum[MSB];
                nf.v = add_ovf;
                nf.z = (add_sum == '0);
                nf.c = add_co;
                we   = MASK_ALL;
            end
            OP_CMP: begin
                nf.n = add_sum[MSB];
                nf.z = (add_sum == '0);
                nf.c = add_co;
                we   = MASK_NZC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res  = (op == OP_AND) ? and_r : (op == OP_OR) ? or_r : xor_r;
                nf.n = res[MSB];
                nf.z = (res == '0);
                we   = MASK_NZ;
            end
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                res  = sh_out;
                nf.n = sh_out[MSB];
                nf.z = (sh_out == '0);
                nf.c = sh_bit;
                we   = MASK_NZC;
            end
            OP_INC, OP_DEC: begin
                res  = add_sum;
                nf.n = add_sum[MSB];
                nf.z = (add_sum == '0);
                we   = MASK_NZ;
            end
            OP_TST: begin
                nf.n = m_in[MSB];
                nf.v = m_in[MSB-1];
                nf.z = (and_r == '0);
                we   = MASK_NVZ;
            end
            OP_TSTI: begin
                nf.z = (and_r == '0);
                we   = MASK_Z;
            end
            OP_PASS: begin
                res  = unary;
                nf.n = unary[MSB];
                nf.z = (unary == '0);
                we   = MASK_NZ;
            end
            default: ;
        endcase
    end

    assign res_out  = res;
    assign flag_nxt = nf;
    assign flag_we  = we;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [3:0]       op_sel,
    input logic             use_mem,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] m_in,
    input logic             c_in,
    input logic [WIDTH-1:0] res_out,
    input logic [3:0]       flag_nxt,
    input logic [3:0]       flag_we
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   plain_sum;
    logic [WIDTH-1:0] opnd;

    assign plain_sum = {1'b0, a_in} + {1'b0, m_in} + {{WIDTH{1'b0}}, c_in};
    assign opnd      = use_mem ? m_in : a_in;

    always_comb begin
        // R1
        add_carry_chk: assert (op_sel != OP_ADD ||
            (flag_we == 4'b1111 && flag_nxt[0] == plain_sum[WIDTH] &&
             res_out == plain_sum[MSB:0]));
        // R3
        cmp_keep_chk: assert (op_sel != OP_CMP ||
            (res_out == a_in && flag_nxt[0] == (a_in >= m_in) &&
             flag_nxt[1] == (a_in == m_in) && flag_we == 4'b1011));
        // R4
        logic_mask_chk: assert (!(op_sel == OP_AND || op_sel == OP_OR ||
            op_sel == OP_XOR) || flag_we == 4'b1010);
        // R5
        shl_out_chk: assert (op_sel != OP_SHL ||
            (flag_nxt[0] == opnd[MSB] && res_out[0] == 1'b0));
        // R6
        rotr_fill_chk: assert (op_sel != OP_ROTR ||
            (res_out[MSB] == c_in && flag_nxt[0] == opnd[0]));
        // R7
        inc_wrap_chk: assert (op_sel != OP_INC ||
            res_out == WIDTH'(opnd + 1'b1));
        // R8
        tst_copy_chk: assert (op_sel != OP_TST ||
            (flag_nxt[3] == m_in[MSB] && flag_nxt[2] == m_in[MSB-1] &&
             res_out == a_in));
        // R9
        tsti_mask_chk: assert (op_sel != OP_TSTI ||
            (flag_we == 4'b0010 && res_out == a_in));
        // R11
        masked_zero_chk: assert ((flag_nxt & ~flag_we) == 4'b0000);
    end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = 4'd0;
    logic       use_mem = 1'b0;
    logic [7:0] a_in = 8'd0;
    logic [7:0] m_in = 8'd0;
    logic       c_in = 1'b0;
    logic [7:0] res_out;
    logic [3:0] flag_nxt;
    logic [3:0] flag_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu #(.WIDTH(8)) dut_i (
        .op_sel   (op_sel),
        .use_mem  (use_mem),
        .a_in     (a_in),
        .m_in     (m_in),
        .c_in     (c_in),
        .res_out  (res_out),
        .flag_nxt (flag_nxt),
        .flag_we  (flag_we)
    );

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R4";
            5: return "R3";
            6, 7: return "R5";
            8, 9: return "R6";
            10, 11: return "R7";
            12: return "R8";
            13: return "R9";
            14: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic, flags packed {N,V,Z,C}
    task automatic model(input int op, input int um, input int a, input int m,
                         input int c, output int r, output int f, output int w);
        int s, src, n, v, z, cy, nm;
        src = um ? m : a;
        r = a; n = 0; v = 0; z = 0; cy = 0; w = 0;
        case (op)
            0, 1: begin
                nm = (op == 0) ? m : 255 - m;
                s  = a + nm + c;
                r  = s % 256;
                cy = (s > 255);
                v  = (((a ^ r) & (nm ^ r) & 128) != 0);
                n  = (r >= 128); z = (r == 0); w = 15;
            end
            5: begin
                s = (a - m + 256) % 256;
                n = (s >= 128); z = (a == m); cy = (a >= m); w = 11;
            end
            2, 3, 4: begin
                r = (op == 2) ? (a & m) : (op == 3) ? (a | m) : (a ^ m);
                n = (r >= 128); z = (r == 0); w = 10;
            end
            6, 8: begin
                cy = src / 128;
                r  = ((src * 2) % 256) + ((op == 8) ? c : 0);
                n = (r >= 128); z = (r == 0); w = 11;
            end
            7, 9: begin
                cy = src % 2;
                r  = (src / 2) + ((op == 9) ? c * 128 : 0);
                n = (r >= 128); z = (r == 0); w = 11;
            end
            10, 11: begin
                r = (op == 10) ? (src + 1) % 256 : (src + 255) % 256;
                n = (r >= 128); z = (r == 0); w = 10;
            end
            12: begin
                n = m / 128; v = (m / 64) % 2; z = ((a & m) == 0); w = 14;
            end
            13: begin
                z = ((a & m) == 0); w = 2;
            end
            14: begin
                r = src; n = (r >= 128); z = (r == 0); w = 10;
            end
            default: ;
        endcase
        f = n * 8 + v * 4 + z * 2 + cy;
    endtask

    task automatic drive(input int op, input int um, input int a, input int m, input int c);
        @(negedge clk);
        op_sel  = op[3:0];
        use_mem = um[0];
        a_in    = a[7:0];
        m_in    = m[7:0];
        c_in    = c[0];
        #1;
    endtask

    task automatic compare(input string tag, input int er, input int ef, input int ew);
        checks++;
        if (res_out !== er[7:0] || flag_nxt !== ef[3:0] || flag_we !== ew[3:0]) begin
            errors++;
            $display("FAIL %s: op=%0d a=%02h m=%02h c=%0d got res=%02h flags=%04b mask=%04b expected res=%02h flags=%04b mask=%04b",
                     tag, op_sel, a_in, m_in, c_in, res_out, flag_nxt, flag_we,
                     er[7:0], ef[3:0], ew[3:0]);
        end
    endtask

    task automatic directed(input string tag, input int op, input int um, input int a,
                            input int m, input int c, input int er, input int ef, input int ew);
        drive(op, um, a, m, c);
        compare(tag, er, ef, ew);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r, f, w;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: all-zero add yields zero result with Z set (R1)
        directed("R1", 0, 0, 8'h00, 8'h00, 0, 8'h00, 4'b0010, 4'b1111);
        // R1: zero, carry and overflow together
        directed("R1", 0, 0, 8'h80, 8'h80, 0, 8'h00, 4'b0111, 4'b1111);
        directed("R1", 0, 0, 8'h7F, 8'h01, 0, 8'h80, 4'b1100, 4'b1111);
        directed("R1", 0, 0, 8'hFF, 8'h00, 1, 8'h00, 4'b0011, 4'b1111);
        // R2: borrow and signed overflow
        directed("R2", 1, 0, 8'h00, 8'h01, 1, 8'hFF, 4'b1000, 4'b1111);
        directed("R2", 1, 0, 8'h80, 8'h01, 1, 8'h7F, 4'b0101, 4'b1111);
        directed("R2", 1, 0, 8'h05, 8'h05, 0, 8'hFF, 4'b1000, 4'b1111);
        // R3: compare equal / less, accumulator unchanged
        directed("R3", 5, 0, 8'h05, 8'h05, 0, 8'h05, 4'b0011, 4'b1011);
        directed("R3", 5, 0, 8'h04, 8'h05, 1, 8'h04, 4'b1000, 4'b1011);
        // R4
        directed("R4", 2, 0, 8'hF0, 8'h0F, 1, 8'h00, 4'b0010, 4'b1010);
        directed("R4", 3, 0, 8'h80, 8'h01, 0, 8'h81, 4'b1000, 4'b1010);
        directed("R4", 4, 0, 8'hAA, 8'hAA, 1, 8'h00, 4'b0010, 4'b1010);
        // R5: shifts insert 0 even with carry set
        directed("R5", 6, 0, 8'h81, 8'h00, 1, 8'h02, 4'b0001, 4'b1011);
        directed("R5", 7, 1, 8'h00, 8'h01, 1, 8'h00, 4'b0011, 4'b1011);
        // R6: rotates move old carry in
        directed("R6", 9, 0, 8'h01, 8'h00, 1, 8'h80, 4'b1001, 4'b1011);
        directed("R6", 8, 1, 8'h00, 8'h80, 0, 8'h00, 4'b0011, 4'b1011);
        // R7: both operand sources, wrap both ways
        directed("R7", 10, 1, 8'h33, 8'hFF, 0, 8'h00, 4'b0010, 4'b1010);
        directed("R7", 11, 0, 8'h00, 8'h55, 1, 8'hFF, 4'b1000, 4'b1010);
        // R8 / R9: bit test forms
        directed("R8", 12, 0, 8'h0F, 8'hC0, 0, 8'h0F, 4'b1110, 4'b1110);
        directed("R8", 12, 0, 8'h01, 8'h01, 1, 8'h01, 4'b0000, 4'b1110);
        directed("R9", 13, 0, 8'h0F, 8'hC0, 1, 8'h0F, 4'b0010, 4'b0010);
        // R10: pass-through, both sources
        directed("R10", 14, 1, 8'h12, 8'h00, 0, 8'h00, 4'b0010, 4'b1010);
        directed("R10", 14, 0, 8'h90, 8'h00, 0, 8'h90, 4'b1000, 4'b1010);
        // R11: reserved code writes nothing
        directed("R11", 15, 1, 8'hA5, 8'h3C, 1, 8'hA5, 4'b0000, 4'b0000);
        // Random sweep against the reference model, every op code
        for (int i = 0; i < 3000; i++) begin
            int op, um, a, m, c;
            op = i % 16;
            um = $urandom_range(1, 0);
            a  = $urandom_range(255, 0);
            m  = $urandom_range(255, 0);
            c  = $urandom_range(1, 0);
            drive(op, um, a, m, c);
            model(op, um, a, m, c, r, f, w);
            compare(tag_of(op), r, f, w);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule